// File: doc/BRIEF.md
# Waveform Recorder Acquisition Sequencer

This block is the mode controller of a multi-channel switched-capacitor waveform recorder. While nothing is happening it drives a circular write pointer across the storage cells. Exactly one cell write enable is high in any clock cycle, and the pointer moves to the next cell on every clock. The analog front end therefore always holds the most recent window of the input.

When a trigger arrives, the sequencer drops every write enable in the same step, so the stored samples are frozen. It records which cell was being written and pulses a start request to the converter bank, which digitizes all cells of all channels together. The sequencer waits for the converter's done signal. It then paces the digitized samples out one per read period, in order: every cell of data channel 0, then every cell of channel 1, and so on. Each sample comes with its channel and cell address and a valid strobe. The observation channel that only monitors the sampling window is never addressed. After the last sample the write pointer restarts at cell 0. Triggers that arrive while conversion or readout is in progress are ignored, and a busy flag covers that whole span.

Top module: `wfr_acq_seq`

## Requirements
- R1: In write mode (`mode_o` = 0) `wr_en_o` has exactly one bit set, and that bit moves from cell k to cell k+1 on every clock, wrapping from the last cell to cell 0.
- R2: From the first cycle after an accepted trigger until the return to write mode, `wr_en_o` is all zero.
- R3: `conv_start_o` is high for exactly one cycle, the first cycle after a trigger is accepted, with `mode_o` = 1. `conv_done_i` is acted on only in mode 1 when `conv_start_o` is low. In any other cycle it has no effect.
- R4: `trig_cell_o` shows the index of the cell whose write enable was high in the cycle the trigger was sampled. It keeps that value until the next accepted trigger, and it is 0 after reset.
- R5: After an accepted `conv_done_i` the sequencer enters read mode (`mode_o` = 2). `rd_valid_o` is then high for one cycle out of every RD_DIV cycles, with the first strobe in the RD_DIV-th cycle of read mode.
- R6: The strobes carry the addresses channel 0 cells 0 to NCELLS-1, then channel 1, and so on up to channel NCH-1. That is exactly NCH*NCELLS strobes, and `rd_chan_o` never reaches NCH (the observation channel).
- R7: A trigger sampled in mode 1 or 2 has no effect. `busy_o` is high exactly while `mode_o` is 1 or 2.
- R8: In the cycle after the final strobe, `mode_o` is 0 and `wr_en_o` selects cell 0. From there it advances as in R1.
- R9: During and straight after reset: `mode_o` = 0, `wr_en_o` selects cell 0, and `busy_o`, `conv_start_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Acquisition trigger, sampled on the clock edge |
| conv_done_i | input | 1 | Converter bank reports conversion finished |
| conv_start_o | output | 1 | One-cycle request to start the shared conversion |
| wr_en_o | output | NCELLS | One-hot cell write enables, all zero while frozen |
| busy_o | output | 1 | High during conversion and readout |
| mode_o | output | 2 | 0 write, 1 convert, 2 read |
| trig_cell_o | output | $clog2(NCELLS) | Cell being written when the trigger was taken |
| rd_valid_o | output | 1 | Sample strobe on the read interface |
| rd_chan_o | output | $clog2(NCH) | Channel address of the strobed sample |
| rd_cell_o | output | $clog2(NCELLS) | Cell address of the strobed sample |

## Verification
A corrupted write pointer shows up on `wr_en_o` in the very next cycle, as a skipped or repeated cell or as two bits high. After a trigger it also shows up in `trig_cell_o`. A slip in the read divider or the address counters misplaces the first strobe at once, and every strobe after it then carries a shifted address. A mode register that fails to freeze, or that returns early, is visible within one cycle on `busy_o` and `wr_en_o`. Random trigger positions, random conversion latency, stray triggers and stray done pulses are compared cycle by cycle against an independent model of the sequence.

// File: rtl/wfr_acq_pkg.sv
package wfr_acq_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_CONV  = 2'd1,
    MODE_READ  = 2'd2
  } acq_mode_e;
endpackage

// File: rtl/wfr_phase_gen.sv
module wfr_phase_gen #(
  parameter int NCELLS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_i,
  input  logic                      restart_i,
  output logic [$clog2(NCELLS)-1:0] idx_o,
  output logic [NCELLS-1:0]         wr_en_o
);
  localparam int CW = $clog2(NCELLS);
  localparam logic [CW-1:0] LAST = CW'(NCELLS - 1);

  logic [CW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (restart_i)  idx_d = '0;
    else if (run_i) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idx_q <= '0;
    else if (restart_i || run_i) idx_q <= idx_d;
  end

  for (genvar c = 0; c < NCELLS; c++) begin : g_dec
    assign wr_en_o[c] = run_i && (idx_q == CW'(c));
  end

  assign idx_o = idx_q;

  // R1: at most one cell enabled, and one exactly while running
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> $onehot(wr_en_o));
  // R1: the pointer steps by one cell, wrapping at the end
  assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !restart_i) |=>
      idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1));
  // R8: a restart lands on cell 0
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> idx_q == '0);
endmodule

// File: rtl/wfr_read_walker.sv
module wfr_read_walker #(
  parameter int NCH    = 4,
  parameter int NCELLS = 256,
  parameter int RD_DIV = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start_i,
  input  logic                                   run_i,
  output logic                                   valid_o,
  output logic                                   last_o,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] chan_o,
  output logic [$clog2(NCELLS)-1:0]              cell_o
);
  localparam int CW = $clog2(NCELLS);
  localparam int HW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int DW = (RD_DIV > 1) ? $clog2(RD_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST  = DW'(RD_DIV - 1);
  localparam logic [CW-1:0] CELL_LAST = CW'(NCELLS - 1);
  localparam logic [HW-1:0] CHAN_LAST = HW'(NCH - 1);

  logic [DW-1:0] div_q, div_d;
  logic [CW-1:0] cell_q, cell_d;
  logic [HW-1:0] chan_q, chan_d;
  logic          tick;

  assign tick = run_i && (div_q == DIV_LAST);

  always_comb begin
    div_d  = div_q;
    cell_d = cell_q;
    chan_d = chan_q;
    if (start_i) begin
      div_d  = '0;
      cell_d = '0;
      chan_d = '0;
    end else if (run_i) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (cell_q == CELL_LAST) begin
          cell_d = '0;
          chan_d = (chan_q == CHAN_LAST) ? '0 : chan_q + 1'b1;
        end else begin
          cell_d = cell_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cell_q <= '0;
      chan_q <= '0;
    end else if (start_i || run_i) begin
      div_q  <= div_d;
      cell_q <= cell_d;
      chan_q <= chan_d;
    end
  end

  assign valid_o = tick;
  assign last_o  = tick && (cell_q == CELL_LAST) && (chan_q == CHAN_LAST);
  assign chan_o  = chan_q;
  assign cell_o  = cell_q;

  // R6: the observation channel is never addressed
  assert_chan_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(chan_o) < NCH));
  // R5: strobes are spaced by the read divider
  if (RD_DIV > 1) begin : g_spacing
    assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
  end
  // R6: a fresh readout starts at channel 0, cell 0
  assert_start_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (chan_q == '0 && cell_q == '0));
endmodule

// File: rtl/wfr_mode_fsm.sv
module wfr_mode_fsm
  import wfr_acq_pkg::*;
#(
  parameter int NCELLS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig_i,
  input  logic                      conv_done_i,
  input  logic                      rd_last_i,
  input  logic [$clog2(NCELLS)-1:0] cell_idx_i,
  output acq_mode_e                 mode_o,
  output logic                      conv_start_o,
  output logic                      enter_read_o,
  output logic                      finish_o,
  output logic [$clog2(NCELLS)-1:0] trig_cell_o
);
  localparam int CW = $clog2(NCELLS);

  acq_mode_e     mode_q, mode_d;
  logic          start_q, start_d;
  logic [CW-1:0] tcell_q;
  logic          take_trig;

  assign take_trig    = (mode_q == MODE_WRITE) && trig_i;
  assign enter_read_o = (mode_q == MODE_CONV) && conv_done_i && !start_q;
  assign finish_o     = (mode_q == MODE_READ) && rd_last_i;

  always_comb begin
    mode_d  = mode_q;
    start_d = take_trig;
    unique case (mode_q)
      MODE_WRITE: if (take_trig)    mode_d = MODE_CONV;
      MODE_CONV:  if (enter_read_o) mode_d = MODE_READ;
      MODE_READ:  if (finish_o)     mode_d = MODE_WRITE;
      default:                      mode_d = MODE_WRITE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_WRITE;
      start_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tcell_q <= '0;
    else if (take_trig) tcell_q <= cell_idx_i;
  end

  assign mode_o       = mode_q;
  assign conv_start_o = start_q;
  assign trig_cell_o  = tcell_q;

  // R3: the start request lasts one cycle
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R3: the start request only appears in conversion mode
  assert_start_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> mode_q == MODE_CONV);
  // R7: triggers while busy leave the latched cell alone
  assert_trig_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_WRITE) |=> $stable(tcell_q));
  // R5: readout is entered only from conversion
  assert_read_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && $past(mode_q) != MODE_READ) |-> $past(mode_q) == MODE_CONV);
endmodule

// File: rtl/wfr_acq_seq.sv
module wfr_acq_seq
  import wfr_acq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NCELLS = 256,
  parameter int RD_DIV = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     trig_i,
  input  logic                                     conv_done_i,
  output logic                                     conv_start_o,
  output logic [NCELLS-1:0]                        wr_en_o,
  output logic                                     busy_o,
  output logic [1:0]                               mode_o,
  output logic [$clog2(NCELLS)-1:0]                trig_cell_o,
  output logic                                     rd_valid_o,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] rd_chan_o,
  output logic [$clog2(NCELLS)-1:0]                rd_cell_o
);
  localparam int CW = $clog2(NCELLS);

  acq_mode_e     mode;
  logic [CW-1:0] cell_idx;
  logic          rd_last, enter_read, finish;

  wfr_mode_fsm #(.NCELLS(NCELLS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .conv_done_i (conv_done_i),
    .rd_last_i   (rd_last),
    .cell_idx_i  (cell_idx),
    .mode_o      (mode),
    .conv_start_o(conv_start_o),
    .enter_read_o(enter_read),
    .finish_o    (finish),
    .trig_cell_o (trig_cell_o)
  );

  wfr_phase_gen #(.NCELLS(NCELLS)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (mode == MODE_WRITE),
    .restart_i(finish),
    .idx_o    (cell_idx),
    .wr_en_o  (wr_en_o)
  );

  wfr_read_walker #(.NCH(NCH), .NCELLS(NCELLS), .RD_DIV(RD_DIV)) u_read (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(enter_read),
    .run_i  (mode == MODE_READ),
    .valid_o(rd_valid_o),
    .last_o (rd_last),
    .chan_o (rd_chan_o),
    .cell_o (rd_cell_o)
  );

  assign busy_o = (mode != MODE_WRITE);
  assign mode_o = mode;

  // R2: cells stay frozen while busy
  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (wr_en_o == '0));
  // R5: no sample strobe outside read mode
  assert_valid_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> mode_o == 2'd2);
  // R8: the final strobe hands back to write mode at cell 0
  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_last) |=> (mode_o == 2'd0 && wr_en_o[0]));
endmodule

// File: tb/wfr_acq_seq_test.sv
module wfr_acq_seq_test;
  localparam int NCH    = 4;
  localparam int NCELLS = 256;
  localparam int RD_DIV = 4;
  localparam int CW     = $clog2(NCELLS);
  localparam int HW     = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic done = 1'b0;
  logic              conv_start, busy, rd_valid;
  logic [NCELLS-1:0] wr_en;
  logic [1:0]        mode;
  logic [CW-1:0]     trig_cell, rd_cell;
  logic [HW-1:0]     rd_chan;

  always #2 clk = ~clk;

  wfr_acq_seq #(.NCH(NCH), .NCELLS(NCELLS), .RD_DIV(RD_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .conv_done_i(done),
    .conv_start_o(conv_start), .wr_en_o(wr_en), .busy_o(busy), .mode_o(mode),
    .trig_cell_o(trig_cell), .rd_valid_o(rd_valid), .rd_chan_o(rd_chan),
    .rd_cell_o(rd_cell)
  );

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;

  // reference model state
  int m_mode = 0, m_idx = 0, m_tcell = 0, m_start = 0;
  int m_div = 0, m_ch = 0, m_cell = 0, m_nstrobe = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NCELLS-1:0] onehot_of(input int i);
    logic [NCELLS-1:0] one = 1;
    return one << i;
  endfunction

  function automatic bit exp_valid();
    return (m_mode == 2) && (m_div == RD_DIV - 1);
  endfunction

  // model advance on the clock edge
  always @(posedge clk) begin
    if (rst_n && chk_on) begin
      case (m_mode)
        0: begin
          m_start <= 0;
          if (trig) begin
            m_tcell <= m_idx;
            m_mode  <= 1;
            m_start <= 1;
          end
          m_idx <= (m_idx + 1) % NCELLS;
        end
        1: begin
          m_start <= 0;
          if (done && !m_start) begin
            m_mode <= 2; m_div <= 0; m_ch <= 0; m_cell <= 0; m_nstrobe <= 0;
          end
        end
        default: begin
          if (m_div == RD_DIV - 1) begin
            m_div <= 0;
            m_nstrobe <= m_nstrobe + 1;
            if (m_ch == NCH - 1 && m_cell == NCELLS - 1) begin
              chk(m_nstrobe + 1 == NCH * NCELLS, "R6 strobe count",
                  256'(m_nstrobe + 1), 256'(NCH * NCELLS));
              m_mode <= 0; m_idx <= 0;
            end else if (m_cell == NCELLS - 1) begin
              m_cell <= 0; m_ch <= m_ch + 1;
            end else begin
              m_cell <= m_cell + 1;
            end
          end else begin
            m_div <= m_div + 1;
          end
        end
      endcase
    end
  end

  // compare outputs away from the edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      logic [NCELLS-1:0] ew;
      ew = (m_mode == 0) ? onehot_of(m_idx) : '0;
      chk(wr_en == ew, (m_mode == 0) ? "R1 write enable" : "R2 frozen cells",
          256'(wr_en), 256'(ew));
      chk(int'(mode) == m_mode, "R7 mode", 256'(mode), 256'(m_mode));
      chk(busy == (m_mode != 0), "R7 busy", 256'(busy), 256'(m_mode != 0));
      chk(conv_start == (m_start != 0), "R3 start pulse", 256'(conv_start),
          256'(m_start));
      chk(int'(trig_cell) == m_tcell, "R4 trigger cell", 256'(trig_cell),
          256'(m_tcell));
      chk(rd_valid == exp_valid(), "R5 strobe timing", 256'(rd_valid),
          256'(exp_valid()));
      if (rd_valid && exp_valid())
        chk(int'(rd_chan) == m_ch && int'(rd_cell) == m_cell, "R6 read address",
            256'({rd_chan, rd_cell}), 256'((m_ch << CW) | m_cell));
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
      summary();
    end
  end

  task automatic acquire(input int wt, input int cd, input bit early_done,
                         input bit noise);
    repeat (wt) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (early_done) begin  // R3: done during start cycle must be ignored
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
    end
    for (int k = 0; k < cd; k++) begin
      if (noise) trig = ($urandom % 2) == 1;  // R7: stray triggers
      @(negedge clk);
    end
    trig = 1'b0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    while (m_mode != 0) begin
      if (noise) begin
        trig = ($urandom % 7) == 0;
        done = ($urandom % 9) == 0;
      end
      @(negedge clk);
    end
    trig = 1'b0;
    done = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R9: reset values while held in reset
    chk(mode == 2'd0 && !busy && !conv_start && !rd_valid, "R9 reset flags",
        256'({mode, busy, conv_start, rd_valid}), 256'(0));
    chk(wr_en == onehot_of(0), "R9 reset write enable", 256'(wr_en),
        256'(onehot_of(0)));
    chk(trig_cell == '0, "R4 reset trigger cell", 256'(trig_cell), 256'(0));
    chk_on = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    // R3: done pulses in write mode do nothing
    done = 1'b1;
    repeat (5) @(negedge clk);
    done = 1'b0;
    // trigger on the first cycles after reset, done late
    acquire(0, 3, 1'b0, 1'b0);
    // R8: after return the pointer walks past a full wrap
    repeat (NCELLS + 10) @(negedge clk);
    // R4: trigger on the last cell, with an early done
    while (m_idx != NCELLS - 1) @(negedge clk);
    acquire(0, 0, 1'b1, 1'b1);
    // R1 wrap: trigger right at cell 0
    while (m_idx != 0) @(negedge clk);
    acquire(0, 1, 1'b0, 1'b0);
    // random acquisitions with stray inputs
    for (int n = 0; n < 6; n++)
      acquire(int'($urandom % 600), 1 + int'($urandom % 40),
              ($urandom % 2) == 1, 1'b1);
    repeat (20) @(negedge clk);
    summary();
  end
endmodule